// File: doc/BRIEF.md
# DMA Request Line Frame Receiver

This block sits on the host side of one serial DMA request wire from a low-pin-count peripheral. The wire idles high and is sampled on every rising edge of the bus clock. A frame begins with a low start bit. Three channel bits follow, most significant first, and then an activity bit. When the activity bit is high, the named channel's bit in an eight-entry pending-request vector is set. When it is low, that bit is withdrawn. The block does not arbitrate between channels and does not run bus cycles. It only keeps the request bitmap up to date, and the DMA engine reads it.

Each decoded frame also produces a one-cycle event that carries the channel and the activity bit. After the activity bit, the line must be high for at least one clock. A low level in that slot is a framing error: the frame is still applied, an error pulse is raised, and the receiver waits for the line to go high before it looks for a new start. A service-clear input lets the DMA engine drop a request once it has been served. A constant per-channel kind vector reports which channels carry bytes, which carry 16-bit words, and which one is the bus-master request. A host with two peripherals instantiates two copies.

Top module: `dreq_frame_rx`

## Requirements
- R1: After synchronous reset, `pending` is all zero, `evt_valid` and `frame_err` are low, and the receiver is looking for a start bit.
- R2: While the receiver is looking for a start, a high sample has no effect. A low sample is taken as a start bit.
- R3: The three samples after the start bit are the channel number, most significant bit first.
- R4: A high activity bit (the fourth sample after the start) sets `pending[chan]`. On the same clock edge, `evt_valid` pulses for one cycle with `evt_chan` equal to the channel and `evt_act` equal to 1.
- R5: A low activity bit clears `pending[chan]` and pulses the event with `evt_act` equal to 0.
- R6: A single high sample after the activity bit is enough. A low sample on the next edge starts a new frame.
- R7: A low sample in the gap slot makes `frame_err` pulse for one cycle on that edge. The frame is still applied. Low samples after that start no frame until a high sample is seen.
- R8: `svc_clr_valid` with `svc_clr_chan` clears that pending bit on the next edge. If a set for the same channel is decoded on that same edge, the bit ends up set.
- R9: A frame or a clear changes only the bit of its own channel.
- R10: `chan_kind` holds two bits per channel, with channel n at bits [2n+1:2n]. The codes are 0 for channels 0 to 3 (byte), 1 for channels 5 to 7 (16-bit word) and 2 for channel 4 (bus master).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_line | input | 1 | Serial request wire, idle high |
| svc_clr_valid | input | 1 | Drop a serviced request |
| svc_clr_chan | input | 3 | Channel to drop |
| pending | output | 8 | Pending request bitmap |
| evt_valid | output | 1 | One-cycle decoded-frame pulse |
| evt_chan | output | 3 | Channel of the decoded frame |
| evt_act | output | 1 | Activity bit of the decoded frame |
| frame_err | output | 1 | One-cycle pulse for a low gap slot |
| chan_kind | output | 16 | Two-bit kind code per channel |

## Verification
A set decoded from the line and a service clear from the DMA engine can land on the same clock edge. The same can happen with a withdrawal and a clear. The bench provokes this by raising `svc_clr_valid` in the activity-bit cycle of a frame. Sometimes the clear names the frame's channel and sometimes another channel. The bench's own model keeps set above clear and applies withdraw together with clear. The design's bitmap is compared with that model on every cycle.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  localparam int unsigned KIND_W = 2;
  typedef enum logic [KIND_W-1:0] {
    KIND_BYTE   = 2'd0,
    KIND_WORD   = 2'd1,
    KIND_MASTER = 2'd2
  } chan_kind_e;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_BITS = 2'd1,
    ST_GAP  = 2'd2,
    ST_HOLD = 2'd3
  } rx_state_e;

  function automatic chan_kind_e kind_of(input int unsigned ch);
    if (ch < 4) return KIND_BYTE;
    else if (ch == 4) return KIND_MASTER;
    else return KIND_WORD;
  endfunction
endpackage

// File: rtl/dreq_frame_dec.sv
module dreq_frame_dec
  import dreq_pkg::*;
#(
  parameter int unsigned CHAN_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 line_i,
  output logic                 dec_valid,
  output logic [CHAN_BITS-1:0] dec_chan,
  output logic                 dec_act,
  output logic                 dec_err
);
  localparam int unsigned CNT_W = $clog2(CHAN_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAN_BITS);

  rx_state_e            state;
  logic [CNT_W-1:0]     cnt;
  logic [CHAN_BITS-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_HUNT;
      cnt       <= '0;
      shreg     <= '0;
      dec_valid <= 1'b0;
      dec_chan  <= '0;
      dec_act   <= 1'b0;
      dec_err   <= 1'b0;
    end else begin
      dec_valid <= 1'b0;
      dec_err   <= 1'b0;
      unique case (state)
        ST_HUNT: begin
          if (!line_i) begin
            state <= ST_BITS;
            cnt   <= '0;
          end
        end
        ST_BITS: begin
          if (cnt != LAST) begin
            shreg <= {shreg[CHAN_BITS-2:0], line_i};
            cnt   <= cnt + 1'b1;
          end else begin
            dec_valid <= 1'b1;
            dec_chan  <= shreg;
            dec_act   <= line_i;
            state     <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (line_i) state <= ST_HUNT;
          else begin
            dec_err <= 1'b1;
            state   <= ST_HOLD;
          end
        end
        default: begin
          if (line_i) state <= ST_HUNT;
        end
      endcase
    end
  end
endmodule

// File: rtl/dreq_pend_bank.sv
module dreq_pend_bank #(
  parameter int unsigned CHAN_BITS = 3,
  localparam int unsigned NCH = 1 << CHAN_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd_valid,
  input  logic [CHAN_BITS-1:0] upd_chan,
  input  logic                 upd_act,
  input  logic                 clr_valid,
  input  logic [CHAN_BITS-1:0] clr_chan,
  output logic [NCH-1:0]       pend_q
);
  logic [NCH-1:0] set_m, drop_m;

  always_comb begin
    set_m  = '0;
    drop_m = '0;
    if (upd_valid) begin
      if (upd_act) set_m[upd_chan]  = 1'b1;
      else         drop_m[upd_chan] = 1'b1;
    end
    if (clr_valid) drop_m[clr_chan] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~drop_m) | set_m;
  end
endmodule

// File: rtl/dreq_frame_rx.sv
module dreq_frame_rx
  import dreq_pkg::*;
#(
  parameter int unsigned CHAN_BITS = 3,
  localparam int unsigned NCH = 1 << CHAN_BITS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_line,
  input  logic                    svc_clr_valid,
  input  logic [CHAN_BITS-1:0]    svc_clr_chan,
  output logic [NCH-1:0]          pending,
  output logic                    evt_valid,
  output logic [CHAN_BITS-1:0]    evt_chan,
  output logic                    evt_act,
  output logic                    frame_err,
  output logic [NCH*KIND_W-1:0]   chan_kind
);
  logic                 nx_valid, nx_act;
  logic [CHAN_BITS-1:0] nx_chan;

  // The update is computed from the state before the edge, so the decoded
  // frame and the bitmap change on the same clock edge.
  dreq_frame_dec #(.CHAN_BITS(CHAN_BITS)) u_dec (
    .clk(clk), .rst(rst), .line_i(req_line),
    .dec_valid(evt_valid), .dec_chan(evt_chan), .dec_act(evt_act),
    .dec_err(frame_err)
  );

  dreq_act_peek #(.CHAN_BITS(CHAN_BITS)) u_peek (
    .clk(clk), .rst(rst), .line_i(req_line),
    .nx_valid(nx_valid), .nx_chan(nx_chan), .nx_act(nx_act)
  );

  dreq_pend_bank #(.CHAN_BITS(CHAN_BITS)) u_bank (
    .clk(clk), .rst(rst),
    .upd_valid(nx_valid), .upd_chan(nx_chan), .upd_act(nx_act),
    .clr_valid(svc_clr_valid), .clr_chan(svc_clr_chan),
    .pend_q(pending)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_kind
    assign chan_kind[g*KIND_W +: KIND_W] = kind_of(g);
  end
endmodule

module dreq_act_peek
  import dreq_pkg::*;
#(
  parameter int unsigned CHAN_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 line_i,
  output logic                 nx_valid,
  output logic [CHAN_BITS-1:0] nx_chan,
  output logic                 nx_act
);
  localparam int unsigned CNT_W = $clog2(CHAN_BITS + 2);
  localparam logic [CNT_W-1:0] ACT_SLOT = CNT_W'(CHAN_BITS + 1);

  logic [CNT_W-1:0]     pos;
  logic [CHAN_BITS-1:0] bits;
  logic                 busy, hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos  <= '0;
      bits <= '0;
      busy <= 1'b0;
      hold <= 1'b0;
    end else if (hold) begin
      if (line_i) hold <= 1'b0;
    end else if (!busy) begin
      if (!line_i) begin
        busy <= 1'b1;
        pos  <= CNT_W'(1);
      end
    end else if (pos != ACT_SLOT) begin
      bits <= {bits[CHAN_BITS-2:0], line_i};
      pos  <= pos + 1'b1;
    end else begin
      busy <= 1'b0;
      pos  <= '0;
      hold <= 1'b1;
    end
  end

  // hold covers the gap slot: a high gap releases at once, a low one keeps waiting
  assign nx_valid = busy && (pos == ACT_SLOT);
  assign nx_chan  = bits;
  assign nx_act   = line_i;
endmodule

// File: rtl/dreq_frame_rx_chk.sv
module dreq_frame_rx_chk #(
  parameter int unsigned CHAN_BITS = 3,
  localparam int unsigned NCH = 1 << CHAN_BITS
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_line,
  input logic                 svc_clr_valid,
  input logic [CHAN_BITS-1:0] svc_clr_chan,
  input logic [NCH-1:0]       pending,
  input logic                 evt_valid,
  input logic [CHAN_BITS-1:0] evt_chan,
  input logic                 evt_act,
  input logic                 frame_err
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (pending == '0 && !evt_valid && !frame_err));

  assert_set_visible_R4: assert property (@(posedge clk) disable iff (rst)
    evt_valid && evt_act |-> pending[evt_chan]);

  assert_evt_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    evt_valid |=> !evt_valid);

  assert_withdraw_R5: assert property (@(posedge clk) disable iff (rst)
    evt_valid && !evt_act |-> !pending[evt_chan]);

  assert_err_after_frame_R7: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> !$past(rst) && $past(evt_valid));

  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> !frame_err);

  assert_svc_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $past(svc_clr_valid) && !$past(rst) &&
    !(evt_valid && evt_act && evt_chan == $past(svc_clr_chan))
    |-> !pending[$past(svc_clr_chan)]);
endmodule

bind dreq_frame_rx dreq_frame_rx_chk #(.CHAN_BITS(CHAN_BITS)) u_chk (.*);

// File: tb/tb_dreq_frame_rx.sv
module tb_dreq_frame_rx;
  logic       clk = 1'b0;
  logic       rst;
  logic       req_line;
  logic       svc_clr_valid;
  logic [2:0] svc_clr_chan;
  logic [7:0] pending;
  logic       evt_valid, evt_act, frame_err;
  logic [2:0] evt_chan;
  logic [15:0] chan_kind;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] exp_pend;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dreq_frame_rx dut (
    .clk(clk), .rst(rst), .req_line(req_line),
    .svc_clr_valid(svc_clr_valid), .svc_clr_chan(svc_clr_chan),
    .pending(pending), .evt_valid(evt_valid), .evt_chan(evt_chan),
    .evt_act(evt_act), .frame_err(frame_err), .chan_kind(chan_kind)
  );

  function automatic logic [1:0] exp_kind(input int ch);
    if (ch <= 3) return 2'd0;
    if (ch == 4) return 2'd2;
    return 2'd1;
  endfunction

  function automatic logic [7:0] next_pend(input logic [7:0] p,
      input bit upd, input logic [2:0] ch, input bit act,
      input bit clr, input logic [2:0] cch);
    logic [7:0] r;
    r = p;
    if (clr) r[cch] = 1'b0;
    if (upd && !act) r[ch] = 1'b0;
    if (upd && act) r[ch] = 1'b1;
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, sample after the rising edge.
  task automatic step(input bit ln, input bit clr, input logic [2:0] cch,
                      input bit upd, input logic [2:0] ch, input bit act,
                      input bit err, input string req);
    @(negedge clk);
    req_line = ln; svc_clr_valid = clr; svc_clr_chan = cch;
    @(posedge clk);
    #1;
    exp_pend = next_pend(exp_pend, upd, ch, act, clr, cch);
    chk({req, " pending"}, 32'(pending), 32'(exp_pend));
    chk({req, " evt_valid"}, 32'(evt_valid), 32'(upd));
    if (upd) begin
      chk({req, " evt_chan R3"}, 32'(evt_chan), 32'(ch));
      chk({req, " evt_act"}, 32'(evt_act), 32'(act));
    end
    chk({req, " frame_err R7"}, 32'(frame_err), 32'(err));
  endtask

  // clr_slot: 0..5 slot index in which a clear is driven, -1 none
  task automatic frame(input logic [2:0] ch, input bit act, input bit bad_gap,
                       input int clr_slot, input logic [2:0] cch, input string req);
    step(1'b0, clr_slot == 0, cch, 0, ch, act, 0, req);
    for (int i = 0; i < 3; i++)
      step(ch[2-i], clr_slot == i + 1, cch, 0, ch, act, 0, req);
    step(act, clr_slot == 4, cch, 1, ch, act, 0, req);
    step(!bad_gap, clr_slot == 5, cch, 0, ch, act, bad_gap, req);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(1'b1, 0, 3'd0, 0, 3'd0, 0, 0, req);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst = 1'b1; req_line = 1'b1; svc_clr_valid = 1'b0; svc_clr_chan = '0;
    exp_pend = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 pending", 32'(pending), 0);
    chk("R1 evt_valid", 32'(evt_valid), 0);
    chk("R1 frame_err", 32'(frame_err), 0);
    for (int c = 0; c < 8; c++)
      chk("R10 chan_kind", 32'(chan_kind[2*c +: 2]), 32'(exp_kind(c)));

    idle(5, "R2 idle high");
    frame(3'd5, 1, 0, -1, 0, "R4 set ch5 R3");
    frame(3'd2, 1, 0, -1, 0, "R6 back-to-back R9");
    frame(3'd4, 1, 0, -1, 0, "R6 back-to-back");
    frame(3'd5, 0, 0, -1, 0, "R5 withdraw ch5");
    frame(3'd6, 1, 0, 4, 3'd6, "R8 set wins over clear");
    frame(3'd1, 1, 0, 4, 3'd2, "R8 clear other ch R9");
    frame(3'd6, 0, 0, 4, 3'd6, "R8 withdraw with clear");
    frame(3'd7, 1, 1, -1, 0, "R7 bad gap applied");
    for (int i = 0; i < 4; i++) step(1'b0, 0, 0, 0, 0, 0, 0, "R7 hold while low");
    step(1'b1, 0, 0, 0, 0, 0, 0, "R7 release");
    frame(3'd0, 1, 0, -1, 0, "R7 recovery R3");
    idle(1, "R2");
    step(1'b1, 1, 3'd7, 0, 0, 0, 0, "R8 standalone clear");

    for (int n = 0; n < 600; n++) begin
      logic [2:0] ch, cch;
      bit act, bad;
      int slot;
      ch   = 3'($urandom_range(0, 7));
      cch  = ($urandom_range(0, 1) == 1) ? ch : 3'($urandom_range(0, 7));
      act  = ($urandom_range(0, 3) != 0);
      bad  = ($urandom_range(0, 7) == 0);
      slot = $urandom_range(0, 9) - 3;
      frame(ch, act, bad, slot, cch, "R9 random frame");
      if (bad) begin
        for (int i = 0; i < int'($urandom_range(0, 2)); i++)
          step(1'b0, 0, 0, 0, 0, 0, 0, "R7 random hold");
        step(1'b1, 0, 0, 0, 0, 0, 0, "R7 random release");
      end
      idle($urandom_range(0, 2), "R6 random gap");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule